// File: doc/BRIEF.md
# JTAG Test Access Port Controller with Instruction Decode

This block is the control core of a boundary-scan port. A sixteen-state controller advances on each rising edge of the scan clock and is steered by the mode-select input. It holds a 7-bit instruction register, a 32-bit identification register and a single-bit bypass register. The active instruction decides which data register sits between the serial input and the serial output. Two data paths are outside the block: a boundary register and a one-bit self-test result register. The block drives their select lines and the shared capture, shift and update strobes, and takes their serial outputs back in.

The serial output is retimed on the falling edge of the scan clock. It carries an enable that is high only while an instruction or data shift is in progress. Two pin-control outputs tell the pad ring how to behave. One marks the instructions in which the boundary cells own the pins. The other marks the instruction in which every driver must be released.

Top module: `jtag_tap_ctrl`

## Requirements
- R1: While `jrst_n` is low the controller is held in Test-Logic-Reset and `instr` reads the identification opcode 0000010. `jdo_en` and `pin_mode` are 0 during that time.
- R2: Five rising edges of `jclk` with `jmode` high reach Test-Logic-Reset from any state. On the next edge `instr` becomes 0000010.
- R3: In Capture-IR the instruction shift path loads 0000001. Those bits then leave on `jdo` least significant bit first.
- R4: A shifted opcode changes `instr` only on the rising edge that leaves Update-IR. In Exit1-IR, Pause-IR, Exit2-IR and Update-IR, `instr` keeps its old value.
- R5: With 0000010 active, a 32-bit data scan returns the identity word {version 4'b0001, part 16'b1000001100000010, maker 11'b00000001001, 1'b1}, least significant bit first.
- R6: With 1111111 active, the data path is one bit long. It captures 0, so the output stream is the input stream delayed by one bit, led by a 0.
- R7: Opcodes 0000000 and 0000001 raise `bnd_sel` and route `bnd_so` to `jdo`. `dr_update` pulses once for each data scan.
- R8: Opcode 0000111 raises `bist_sel` and routes `bist_so` to `jdo`.
- R9: `pin_mode` is 1 exactly for opcodes 0000000, 0000100 and 0001000. `hiz` is 1 only for 0001000. Opcodes 0000100 and 0001000 use the bypass path.
- R10: Any opcode outside the seven listed ones behaves as 1111111: neither select is raised and the path is one bit long.
- R11: `jdo` and `jdo_en` change only on falling edges of `jclk`. `jdo_en` is 1 only during Shift-IR and Shift-DR.
- R12: `dr_capture`, `dr_shift` and `dr_update` are never high together. A capture is always followed by Shift-DR or Exit1-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| jclk | input | 1 | Scan clock |
| jrst_n | input | 1 | Asynchronous active-low port reset |
| jmode | input | 1 | Mode select, sampled on rising edge |
| jdi | input | 1 | Serial data in, sampled on rising edge |
| bnd_so | input | 1 | Serial output of the external boundary register |
| bist_so | input | 1 | Serial output of the external self-test result register |
| jdo | output | 1 | Serial data out, changes on falling edge |
| jdo_en | output | 1 | Output enable for `jdo` |
| bnd_sel | output | 1 | Boundary register is the active data path |
| bist_sel | output | 1 | Self-test result register is the active data path |
| dr_capture | output | 1 | Controller is in Capture-DR |
| dr_shift | output | 1 | Controller is in Shift-DR |
| dr_update | output | 1 | Controller is in Update-DR |
| pin_mode | output | 1 | Boundary cells control the pins |
| hiz | output | 1 | All pin drivers released |
| instr | output | IR_LEN | Active instruction |

## Verification
The checker assumes that `jmode` and `jdi` are stable around each rising edge of `jclk`. It also assumes that `jrst_n` is released away from that edge, so every controller transition is a clean one-step move. The bench changes its inputs half a nanosecond after each falling edge and releases reset in the low half of the clock. It reads `jdo` in the low half and reads it again just after the next rising edge, so any change outside a falling edge is caught. The external boundary and self-test registers are small bench models that follow the select and strobe outputs.

// File: rtl/tap_pkg.sv
package tap_pkg;

   typedef enum logic [3:0] {
      TS_RESET, TS_IDLE,
      TS_SEL_DR, TS_CAP_DR, TS_SHF_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
      TS_SEL_IR, TS_CAP_IR, TS_SHF_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
   } tap_state_t;

   typedef enum logic [1:0] {
      PATH_BYPASS, PATH_IDENT, PATH_BOUND, PATH_BIST
   } dr_path_t;

   function automatic tap_state_t tap_next(input tap_state_t s, input logic m);
      case (s)
         TS_RESET:  return m ? TS_RESET  : TS_IDLE;
         TS_IDLE:   return m ? TS_SEL_DR : TS_IDLE;
         TS_SEL_DR: return m ? TS_SEL_IR : TS_CAP_DR;
         TS_CAP_DR: return m ? TS_EX1_DR : TS_SHF_DR;
         TS_SHF_DR: return m ? TS_EX1_DR : TS_SHF_DR;
         TS_EX1_DR: return m ? TS_UPD_DR : TS_PAU_DR;
         TS_PAU_DR: return m ? TS_EX2_DR : TS_PAU_DR;
         TS_EX2_DR: return m ? TS_UPD_DR : TS_SHF_DR;
         TS_UPD_DR: return m ? TS_SEL_DR : TS_IDLE;
         TS_SEL_IR: return m ? TS_RESET  : TS_CAP_IR;
         TS_CAP_IR: return m ? TS_EX1_IR : TS_SHF_IR;
         TS_SHF_IR: return m ? TS_EX1_IR : TS_SHF_IR;
         TS_EX1_IR: return m ? TS_UPD_IR : TS_PAU_IR;
         TS_PAU_IR: return m ? TS_EX2_IR : TS_PAU_IR;
         TS_EX2_IR: return m ? TS_UPD_IR : TS_SHF_IR;
         TS_UPD_IR: return m ? TS_SEL_DR : TS_IDLE;
         default:   return TS_RESET;
      endcase
   endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
   import tap_pkg::*;
(
   input  logic       jclk,
   input  logic       jrst_n,
   input  logic       jmode,
   output tap_state_t st
);

   always_ff @(posedge jclk or negedge jrst_n) begin
      if (!jrst_n) st <= TS_RESET;
      else         st <= tap_next(st, jmode);
   end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
   import tap_pkg::*;
#(
   parameter int                IR_LEN     = 7,
   parameter logic [IR_LEN-1:0] CAPT_PAT   = 7'b0000001,
   parameter logic [IR_LEN-1:0] OP_EXTEST  = 7'b0000000,
   parameter logic [IR_LEN-1:0] OP_SAMPLE  = 7'b0000001,
   parameter logic [IR_LEN-1:0] OP_IDCODE  = 7'b0000010,
   parameter logic [IR_LEN-1:0] OP_CLAMP   = 7'b0000100,
   parameter logic [IR_LEN-1:0] OP_RUNBIST = 7'b0000111,
   parameter logic [IR_LEN-1:0] OP_HIGHZ   = 7'b0001000,
   parameter logic [IR_LEN-1:0] OP_BYPASS  = 7'b1111111,
   parameter bit                ID_PRESENT = 1'b1
) (
   input  logic              jclk,
   input  logic              jrst_n,
   input  logic              jdi,
   input  tap_state_t        st,
   output logic              ir_lsb,
   output logic [IR_LEN-1:0] instr,
   output dr_path_t          path,
   output logic              pin_mode,
   output logic              hiz
);

   localparam logic [IR_LEN-1:0] RST_OP = ID_PRESENT ? OP_IDCODE : OP_BYPASS;

   logic [IR_LEN-1:0] ir_sr;

   always_ff @(posedge jclk or negedge jrst_n) begin
      if (!jrst_n)               ir_sr <= CAPT_PAT;
      else if (st == TS_CAP_IR)  ir_sr <= CAPT_PAT;
      else if (st == TS_SHF_IR)  ir_sr <= {jdi, ir_sr[IR_LEN-1:1]};
   end

   always_ff @(posedge jclk or negedge jrst_n) begin
      if (!jrst_n)               instr <= RST_OP;
      else if (st == TS_RESET)   instr <= RST_OP;
      else if (st == TS_UPD_IR)  instr <= ir_sr;
   end

   assign ir_lsb = ir_sr[0];

   always_comb begin
      path     = PATH_BYPASS;
      pin_mode = 1'b0;
      hiz      = 1'b0;
      if (instr == OP_EXTEST) begin
         path     = PATH_BOUND;
         pin_mode = 1'b1;
      end else if (instr == OP_SAMPLE) begin
         path = PATH_BOUND;
      end else if (instr == OP_IDCODE && ID_PRESENT) begin
         path = PATH_IDENT;
      end else if (instr == OP_RUNBIST) begin
         path = PATH_BIST;
      end else if (instr == OP_CLAMP) begin
         pin_mode = 1'b1;
      end else if (instr == OP_HIGHZ) begin
         pin_mode = 1'b1;
         hiz      = 1'b1;
      end
   end

endmodule

// File: rtl/tap_id_reg.sv
module tap_id_reg #(
   parameter int                VER_W  = 4,
   parameter int                PART_W = 16,
   parameter int                MFR_W  = 11,
   parameter logic [VER_W-1:0]  ID_VER  = 4'b0001,
   parameter logic [PART_W-1:0] ID_PART = 16'b1000001100000010,
   parameter logic [MFR_W-1:0]  ID_MFR  = 11'b00000001001
) (
   input  logic jclk,
   input  logic jrst_n,
   input  logic jdi,
   input  logic cap,
   input  logic shf,
   output logic lsb
);

   localparam int ID_W = VER_W + PART_W + MFR_W + 1;
   localparam logic [ID_W-1:0] ID_WORD = {ID_VER, ID_PART, ID_MFR, 1'b1};

   if (ID_W != 32) begin : g_bad_width
      $error("identity word must total 32 bits");
   end

   logic [ID_W-1:0] sr;

   always_ff @(posedge jclk or negedge jrst_n) begin
      if (!jrst_n)  sr <= ID_WORD;
      else if (cap) sr <= ID_WORD;
      else if (shf) sr <= {jdi, sr[ID_W-1:1]};
   end

   assign lsb = sr[0];

endmodule

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl
   import tap_pkg::*;
#(
   parameter int                IR_LEN     = 7,
   parameter logic [IR_LEN-1:0] CAPT_PAT   = 7'b0000001,
   parameter logic [IR_LEN-1:0] OP_EXTEST  = 7'b0000000,
   parameter logic [IR_LEN-1:0] OP_SAMPLE  = 7'b0000001,
   parameter logic [IR_LEN-1:0] OP_IDCODE  = 7'b0000010,
   parameter logic [IR_LEN-1:0] OP_CLAMP   = 7'b0000100,
   parameter logic [IR_LEN-1:0] OP_RUNBIST = 7'b0000111,
   parameter logic [IR_LEN-1:0] OP_HIGHZ   = 7'b0001000,
   parameter logic [IR_LEN-1:0] OP_BYPASS  = 7'b1111111,
   parameter bit                ID_PRESENT = 1'b1,
   parameter int                VER_W      = 4,
   parameter int                PART_W     = 16,
   parameter int                MFR_W      = 11,
   parameter logic [VER_W-1:0]  ID_VER     = 4'b0001,
   parameter logic [PART_W-1:0] ID_PART    = 16'b1000001100000010,
   parameter logic [MFR_W-1:0]  ID_MFR     = 11'b00000001001
) (
   input  logic              jclk,
   input  logic              jrst_n,
   input  logic              jmode,
   input  logic              jdi,
   input  logic              bnd_so,
   input  logic              bist_so,
   output logic              jdo,
   output logic              jdo_en,
   output logic              bnd_sel,
   output logic              bist_sel,
   output logic              dr_capture,
   output logic              dr_shift,
   output logic              dr_update,
   output logic              pin_mode,
   output logic              hiz,
   output logic [IR_LEN-1:0] instr
);

   if (IR_LEN < 2) begin : g_bad_irlen
      $error("instruction register needs at least two bits");
   end
   if (CAPT_PAT[1:0] != 2'b01) begin : g_bad_capt
      $error("capture pattern must end in 01");
   end
   if (OP_BYPASS != {IR_LEN{1'b1}}) begin : g_bad_bypass
      $error("bypass opcode must be all ones");
   end

   tap_state_t st;
   dr_path_t   path;
   logic       ir_lsb;
   logic       id_lsb;
   logic       byp_q;
   logic       dr_bit;
   logic       shf_ir;

   tap_fsm i_fsm (
      .jclk   (jclk),
      .jrst_n (jrst_n),
      .jmode  (jmode),
      .st     (st)
   );

   tap_ir #(
      .IR_LEN     (IR_LEN),
      .CAPT_PAT   (CAPT_PAT),
      .OP_EXTEST  (OP_EXTEST),
      .OP_SAMPLE  (OP_SAMPLE),
      .OP_IDCODE  (OP_IDCODE),
      .OP_CLAMP   (OP_CLAMP),
      .OP_RUNBIST (OP_RUNBIST),
      .OP_HIGHZ   (OP_HIGHZ),
      .OP_BYPASS  (OP_BYPASS),
      .ID_PRESENT (ID_PRESENT)
   ) i_ir (
      .jclk     (jclk),
      .jrst_n   (jrst_n),
      .jdi      (jdi),
      .st       (st),
      .ir_lsb   (ir_lsb),
      .instr    (instr),
      .path     (path),
      .pin_mode (pin_mode),
      .hiz      (hiz)
   );

   assign dr_capture = (st == TS_CAP_DR);
   assign dr_shift   = (st == TS_SHF_DR);
   assign dr_update  = (st == TS_UPD_DR);
   assign shf_ir     = (st == TS_SHF_IR);
   assign bnd_sel    = (path == PATH_BOUND);
   assign bist_sel   = (path == PATH_BIST);

   if (ID_PRESENT) begin : g_ident
      tap_id_reg #(
         .VER_W   (VER_W),
         .PART_W  (PART_W),
         .MFR_W   (MFR_W),
         .ID_VER  (ID_VER),
         .ID_PART (ID_PART),
         .ID_MFR  (ID_MFR)
      ) i_id (
         .jclk   (jclk),
         .jrst_n (jrst_n),
         .jdi    (jdi),
         .cap    (dr_capture && path == PATH_IDENT),
         .shf    (dr_shift && path == PATH_IDENT),
         .lsb    (id_lsb)
      );
   end else begin : g_no_ident
      assign id_lsb = 1'b0;
   end

   always_ff @(posedge jclk or negedge jrst_n) begin
      if (!jrst_n)                                 byp_q <= 1'b0;
      else if (dr_capture && path == PATH_BYPASS)  byp_q <= 1'b0;
      else if (dr_shift && path == PATH_BYPASS)    byp_q <= jdi;
   end

   always_comb begin
      case (path)
         PATH_IDENT: dr_bit = id_lsb;
         PATH_BOUND: dr_bit = bnd_so;
         PATH_BIST:  dr_bit = bist_so;
         default:    dr_bit = byp_q;
      endcase
   end

   always_ff @(negedge jclk or negedge jrst_n) begin
      if (!jrst_n) begin
         jdo    <= 1'b0;
         jdo_en <= 1'b0;
      end else begin
         jdo_en <= shf_ir || dr_shift;
         if (shf_ir)        jdo <= ir_lsb;
         else if (dr_shift) jdo <= dr_bit;
      end
   end

endmodule

// File: rtl/tap_ctrl_chk.sv
module tap_ctrl_chk
   import tap_pkg::*;
#(
   parameter int                IR_LEN = 7,
   parameter logic [IR_LEN-1:0] RST_OP = 7'b0000010
) (
   input logic              jclk,
   input logic              jrst_n,
   input logic              jdo_en,
   input logic              bnd_sel,
   input logic              bist_sel,
   input logic              dr_capture,
   input logic              dr_shift,
   input logic              dr_update,
   input logic              pin_mode,
   input logic              hiz,
   input logic [IR_LEN-1:0] instr,
   input tap_state_t        st
);

   assert_tlr_reload_R2: assert property (@(posedge jclk) disable iff (!jrst_n)
      (st == TS_RESET) |=> (instr == RST_OP));

   assert_instr_hold_R4: assert property (@(posedge jclk) disable iff (!jrst_n)
      !($past(st) == TS_UPD_IR || $past(st) == TS_RESET) |-> $stable(instr));

   assert_one_path_R7: assert property (@(posedge jclk) disable iff (!jrst_n)
      $onehot0({bnd_sel, bist_sel}));

   assert_hiz_implies_pins_R9: assert property (@(posedge jclk) disable iff (!jrst_n)
      hiz |-> pin_mode);

   assert_enable_in_shift_R11: assert property (@(posedge jclk) disable iff (!jrst_n)
      jdo_en |-> (st == TS_SHF_DR || st == TS_SHF_IR));

   assert_strobes_excl_R12: assert property (@(posedge jclk) disable iff (!jrst_n)
      $onehot0({dr_capture, dr_shift, dr_update}));

   assert_capture_next_R12: assert property (@(posedge jclk) disable iff (!jrst_n)
      dr_capture |=> (dr_shift || st == TS_EX1_DR));

endmodule

bind jtag_tap_ctrl tap_ctrl_chk #(
   .IR_LEN (IR_LEN),
   .RST_OP (ID_PRESENT ? OP_IDCODE : OP_BYPASS)
) i_tap_chk (
   .jclk       (jclk),
   .jrst_n     (jrst_n),
   .jdo_en     (jdo_en),
   .bnd_sel    (bnd_sel),
   .bist_sel   (bist_sel),
   .dr_capture (dr_capture),
   .dr_shift   (dr_shift),
   .dr_update  (dr_update),
   .pin_mode   (pin_mode),
   .hiz        (hiz),
   .instr      (instr),
   .st         (st)
);

// File: tb/test_jtag_tap_ctrl.sv
`timescale 1ns/100ps
module test_jtag_tap_ctrl;

   localparam logic [6:0] C_EXTEST  = 7'b0000000;
   localparam logic [6:0] C_SAMPLE  = 7'b0000001;
   localparam logic [6:0] C_IDCODE  = 7'b0000010;
   localparam logic [6:0] C_CLAMP   = 7'b0000100;
   localparam logic [6:0] C_RUNBIST = 7'b0000111;
   localparam logic [6:0] C_HIGHZ   = 7'b0001000;
   localparam logic [6:0] C_BYPASS  = 7'b1111111;
   localparam logic [31:0] EXP_ID = {4'b0001, 16'b1000001100000010, 11'b00000001001, 1'b1};
   localparam logic [3:0] BND_CAP = 4'b0101;

   logic jclk = 1'b0;
   logic jrst_n = 1'b0;
   logic jmode = 1'b1;
   logic jdi = 1'b0;
   logic bnd_so;
   logic bist_so = 1'b1;
   logic jdo, jdo_en, bnd_sel, bist_sel, dr_capture, dr_shift, dr_update, pin_mode, hiz;
   logic [6:0] instr;

   int checks = 0;
   int errors = 0;
   int edge_bad = 0;
   int upd_cnt = 0;
   logic s_tdo, s_en;
   logic [3:0] bnd_q = 4'b0000;

   always #2 jclk = ~jclk;

   jtag_tap_ctrl i_jtag_tap_ctrl (
      .jclk(jclk), .jrst_n(jrst_n), .jmode(jmode), .jdi(jdi),
      .bnd_so(bnd_so), .bist_so(bist_so),
      .jdo(jdo), .jdo_en(jdo_en), .bnd_sel(bnd_sel), .bist_sel(bist_sel),
      .dr_capture(dr_capture), .dr_shift(dr_shift), .dr_update(dr_update),
      .pin_mode(pin_mode), .hiz(hiz), .instr(instr)
   );

   // external boundary register model
   always @(posedge jclk) begin
      if (bnd_sel && dr_capture)    bnd_q <= BND_CAP;
      else if (bnd_sel && dr_shift) bnd_q <= {jdi, bnd_q[3:1]};
      if (dr_update) upd_cnt <= upd_cnt + 1;
   end
   assign bnd_so = bnd_q[0];

   task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(input logic m, input logic d);
      @(negedge jclk);
      #0.5 jmode = m; jdi = d;
      #0.5 s_tdo = jdo; s_en = jdo_en;
      @(posedge jclk);
      #0.2;
      if (s_en && jdo !== s_tdo) edge_bad++;
   endtask

   task automatic shift_ir(input logic [6:0] code, output logic [6:0] cap, output int en_miss);
      en_miss = 0;
      step(1, 0); step(1, 0); step(0, 0); step(0, 0);
      for (int i = 0; i < 7; i++) begin
         step(i == 6, code[i]);
         cap[i] = s_tdo;
         if (!s_en) en_miss++;
      end
      step(1, 0); step(0, 0);
   endtask

   task automatic shift_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
      dout = '0;
      step(1, 0); step(0, 0); step(0, 0);
      for (int i = 0; i < n; i++) begin
         step(i == n - 1, din[i]);
         dout[i] = s_tdo;
      end
      step(1, 0); step(0, 0);
   endtask

   task automatic t_reset;
      check(instr == C_IDCODE, "R1 reset instr", 32'(instr), 32'(C_IDCODE));
      check(jdo_en == 1'b0 && pin_mode == 1'b0, "R1 reset enable/pin_mode", {30'b0, jdo_en, pin_mode}, 32'h0);
      check(jdo_en == 1'b0, "R11 enable low in idle", 32'(jdo_en), 32'h0);
   endtask

   task automatic t_idcode;
      logic [6:0] cap;
      logic [31:0] d;
      int miss;
      shift_ir(C_IDCODE, cap, miss);
      check(cap == 7'b0000001, "R3 capture pattern", 32'(cap), 32'h1);
      check(miss == 0, "R11 enable high in Shift-IR", 32'(miss), 32'h0);
      shift_dr(32, 32'hA5A5_0F0F, d);
      check(d == EXP_ID, "R5 identity word", d, EXP_ID);
   endtask

   task automatic t_ir_hold;
      step(1, 0); step(1, 0); step(0, 0); step(0, 0);
      for (int i = 0; i < 7; i++) step(i == 6, C_BYPASS[i]);
      check(instr == C_IDCODE, "R4 hold in Exit1-IR", 32'(instr), 32'(C_IDCODE));
      step(0, 0);
      check(instr == C_IDCODE, "R4 hold in Pause-IR", 32'(instr), 32'(C_IDCODE));
      step(1, 0); step(1, 0);
      check(instr == C_IDCODE, "R4 hold in Update-IR", 32'(instr), 32'(C_IDCODE));
      step(0, 0);
      check(instr == C_BYPASS, "R4 change after Update-IR", 32'(instr), 32'(C_BYPASS));
   endtask

   task automatic check_bypass_path(input string tag);
      logic [31:0] d;
      logic [7:0] din = 8'hB6;
      shift_dr(8, 32'(din), d);
      check(d[7:0] == {din[6:0], 1'b0}, tag, d, 32'({din[6:0], 1'b0}));
   endtask

   task automatic t_bypass;
      check(pin_mode == 1'b0 && bnd_sel == 1'b0 && bist_sel == 1'b0, "R6 bypass flags",
            {29'b0, pin_mode, bnd_sel, bist_sel}, 32'h0);
      check_bypass_path("R6 bypass one-bit delay");
      check(edge_bad == 0, "R11 jdo changes on falling edge", 32'(edge_bad), 32'h0);
   endtask

   task automatic t_boundary;
      logic [6:0] cap;
      logic [31:0] d;
      int miss;
      int u0;
      shift_ir(C_EXTEST, cap, miss);
      check(bnd_sel && pin_mode && !hiz, "R9 EXTEST pin_mode=1 hiz=0",
            {29'b0, bnd_sel, pin_mode, hiz}, 32'h6);
      u0 = upd_cnt;
      shift_dr(4, 32'h3, d);
      check(d[3:0] == BND_CAP, "R7 EXTEST boundary data", d, 32'(BND_CAP));
      check(upd_cnt - u0 == 1, "R12 one update per scan", 32'(upd_cnt - u0), 32'h1);
      shift_ir(C_SAMPLE, cap, miss);
      check(bnd_sel && !pin_mode, "R7 SAMPLE selects boundary, pins free",
            {30'b0, bnd_sel, pin_mode}, 32'h2);
      shift_dr(4, 32'hC, d);
      check(d[3:0] == BND_CAP, "R7 SAMPLE boundary data", d, 32'(BND_CAP));
   endtask

   task automatic t_runbist;
      logic [6:0] cap;
      logic [31:0] d;
      int miss;
      shift_ir(C_RUNBIST, cap, miss);
      check(bist_sel && !bnd_sel && !pin_mode, "R8 RUNBIST select",
            {29'b0, bist_sel, bnd_sel, pin_mode}, 32'h4);
      shift_dr(1, 32'h0, d);
      check(d[0] == 1'b1, "R8 result bit routed", d, 32'h1);
   endtask

   task automatic t_clamp_highz;
      logic [6:0] cap;
      int miss;
      shift_ir(C_CLAMP, cap, miss);
      check(pin_mode && !hiz, "R9 CLAMP pin_mode=1 hiz=0", {30'b0, pin_mode, hiz}, 32'h2);
      check_bypass_path("R9 CLAMP uses bypass");
      shift_ir(C_HIGHZ, cap, miss);
      check(pin_mode && hiz, "R9 HIGHZ pin_mode=1 hiz=1", {30'b0, pin_mode, hiz}, 32'h3);
      check_bypass_path("R9 HIGHZ uses bypass");
   endtask

   task automatic t_reserved;
      logic [6:0] cap;
      int miss;
      shift_ir(7'b0000011, cap, miss);
      check(!bnd_sel && !bist_sel && !pin_mode && !hiz, "R10 reserved 0000011 flags",
            {28'b0, bnd_sel, bist_sel, pin_mode, hiz}, 32'h0);
      check_bypass_path("R10 reserved 0000011 bypass");
      shift_ir(7'b1001100, cap, miss);
      check_bypass_path("R10 reserved 1001100 bypass");
   endtask

   task automatic t_tms_reset;
      logic [6:0] cap;
      int miss;
      shift_ir(C_EXTEST, cap, miss);
      step(1, 0); step(0, 0); step(0, 0);
      for (int i = 0; i < 5; i++) step(1, 0);
      step(0, 0);
      check(instr == C_IDCODE, "R2 five-high TMS reset", 32'(instr), 32'(C_IDCODE));
   endtask

   task automatic t_async_reset;
      logic [6:0] cap;
      int miss;
      shift_ir(C_HIGHZ, cap, miss);
      @(negedge jclk);
      #0.5 jrst_n = 1'b0;
      #0.5;
      check(instr == C_IDCODE && !pin_mode && !jdo_en, "R1 async reset",
            {23'b0, instr, pin_mode, jdo_en}, {23'b0, C_IDCODE, 2'b00});
      @(negedge jclk);
      #0.5 jrst_n = 1'b1;
      step(0, 0);
   endtask

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge jclk);
      #0.5 jrst_n = 1'b1;
      step(0, 0);
      t_reset();
      t_idcode();
      t_ir_hold();
      t_bypass();
      t_boundary();
      t_runbist();
      t_clamp_highz();
      t_reserved();
      t_tms_reset();
      t_async_reset();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule